// File: doc/BRIEF.md
# Thermostat Alert With Fault Queue

This block watches a stream of temperature results and decides when a thermal alert is raised and when it is released. Each time the acquisition logic presents a new signed result, the block compares it with a programmable upper limit and a programmable lower limit. The alert only changes state after a programmable number of consecutive qualifying results, so a single noisy sample cannot trip it.

Two behaviours are offered. In comparator behaviour the alert follows the temperature with hysteresis: it is raised by the upper limit and released by the lower one. In interrupt behaviour the alert latches until a clear arrives from the bus side (a read of any register, a won alert-response transfer, or entry into shutdown). After each clear it arms against the opposite limit. A general-call reset returns all internal state to its idle condition. Output polarity is selectable. A status bit always reports the comparator view, and a cause bit reports which limit produced the latched alert. Results and limits may be 12-bit or 13-bit two's-complement values, with 1 LSB equal to 0.0625 °C. The limit registers themselves, and their reset values of 80 °C (0x500) and 75 °C (0x4B0), belong to the register file that feeds this block.

Top module: `thermo_alert`

## Requirements
- R1: The number of consecutive faults needed for a change of state is chosen by `cfgFaultSel`: 2'b00 needs 1, 2'b01 needs 2, 2'b10 needs 4, 2'b11 needs 6.
- R2: In comparator behaviour (`cfgIntMode`=0), the alert becomes active once the selected count of consecutive results are greater than or equal to `highLimit`, with signed comparison.
- R3: An active comparator alert is released only after the selected count of consecutive results strictly below `lowLimit`. A result equal to `lowLimit` is not a fault. Any non-fault result resets the consecutive count.
- R4: In interrupt behaviour (`cfgIntMode`=1), the alert latches after the selected count of results at or above `highLimit`. It stays active through further results until `readClear` or `respWon` is pulsed.
- R5: After each interrupt clear, the block watches `lowLimit`: it latches again only after the selected count of results below `lowLimit`. After the next clear it returns to watching `highLimit`. A clear while nothing is latched has no effect.
- R6: A rising edge of `cfgShutdown` clears a latched interrupt alert in the same way as a read.
- R7: A `genCallReset` pulse clears the comparator state, the latched interrupt, the armed limit and both fault counts.
- R8: `alertPin` is active low when `cfgPolHigh`=0 and active high when `cfgPolHigh`=1.
- R9: `alertStatus` reports the comparator state whatever `cfgIntMode` is. It reads 1 when not alerting and 0 when alerting for `cfgPolHigh`=0, and the inverse for `cfgPolHigh`=1.
- R10: `respCause` is 0 when the latched alert came from the upper limit and 1 when it came from the lower limit, for `cfgPolHigh`=0. It is inverted for `cfgPolHigh`=1. In comparator behaviour the cause is always the upper limit.
- R11: With `cfgExtended`=0, only bits 11:0 of results and limits are used, as a signed 12-bit value. With `cfgExtended`=1, all 13 bits are used as a signed value.
- R12: Outputs reflect a result in the cycle after its `resultValid` strobe. If a clear and a result arrive in the same cycle while an interrupt is latched, the clear wins and that result is not counted toward the interrupt path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| resultValid | input | 1 | One-cycle strobe: a new temperature result is present |
| resultCode | input | 13 | Signed temperature result |
| highLimit | input | 13 | Upper limit, same format as the result |
| lowLimit | input | 13 | Lower limit, same format as the result |
| cfgIntMode | input | 1 | 0 selects comparator behaviour, 1 selects latched interrupt behaviour |
| cfgPolHigh | input | 1 | 0 gives an active-low alert output, 1 gives active high |
| cfgFaultSel | input | 2 | Consecutive-fault count select |
| cfgExtended | input | 1 | 0 uses 12-bit data, 1 uses 13-bit data |
| cfgShutdown | input | 1 | Shutdown level; its rising edge clears a latched interrupt |
| readClear | input | 1 | Pulse: a register read took place |
| respWon | input | 1 | Pulse: an alert-response transfer was won |
| genCallReset | input | 1 | Pulse: general-call reset |
| alertPin | output | 1 | Alert output, polarity set by cfgPolHigh |
| alertStatus | output | 1 | Comparator status bit |
| respCause | output | 1 | Limit that caused the alert, for the alert-response reply |

## Verification
The bench goes after the fault-count boundary for every select value. A queue that is off by one would trip one result early or late. It drives a result exactly equal to the lower limit, which a design using less-or-equal would wrongly treat as a release. It interleaves non-fault results, which a design that fails to reset the count would let accumulate. In interrupt behaviour it checks the upper/lower re-arm sequence, clears that arrive while nothing is latched, and a clear that coincides with a result. A design with the wrong precedence would latch and clear in the wrong order. It also feeds a code whose bit 11 differs from bit 12, so a design that ignores the 12-bit sign extension reports the wrong sign. A sweep over all fault counts, both behaviours, both polarities and both widths compares every output against an arithmetic model.

// File: rtl/thermo_alert_pkg.sv
package thermo_alert_pkg;

  localparam int MAX_FAULTS = 6;
  localparam int CNT_W      = $clog2(MAX_FAULTS + 1);

  typedef struct packed {
    logic cmpCount;
    logic cmpReset;
    logic cmpWatchLow;
    logic intCount;
    logic intReset;
    logic intWatchLow;
  } strobe_t;

  function automatic logic [CNT_W-1:0] faultsNeeded(input logic [1:0] sel);
    case (sel)
      2'b00:   faultsNeeded = CNT_W'(1);
      2'b01:   faultsNeeded = CNT_W'(2);
      2'b10:   faultsNeeded = CNT_W'(4);
      default: faultsNeeded = CNT_W'(6);
    endcase
  endfunction

endpackage

// File: rtl/thermo_alert_datapath.sv
module thermo_alert_datapath
  import thermo_alert_pkg::*;
#(
  parameter int DATA_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [DATA_W-1:0] sample,
  input  logic [DATA_W-1:0] highLimit,
  input  logic [DATA_W-1:0] lowLimit,
  input  logic              extended,
  input  logic [1:0]        faultSel,
  output logic              cmpHit,
  output logic              intHit
);

  localparam int NARROW_W = DATA_W - 1;

  logic signed [DATA_W-1:0] sampleS;
  logic signed [DATA_W-1:0] highS;
  logic signed [DATA_W-1:0] lowS;
  logic                     atOrAboveHigh;
  logic                     belowLow;
  logic [CNT_W-1:0]         needed;
  logic [CNT_W-1:0]         cmpCnt;
  logic [CNT_W-1:0]         intCnt;
  logic                     cmpFault;
  logic                     intFault;

  function automatic logic signed [DATA_W-1:0] widen(input logic [DATA_W-1:0] v,
                                                     input logic wide);
    logic [DATA_W-1:0] r;
    if (wide) r = v;
    else      r = {{(DATA_W-NARROW_W){v[NARROW_W-1]}}, v[NARROW_W-1:0]};
    return $signed(r);
  endfunction

  always_comb begin
    sampleS       = widen(sample, extended);
    highS         = widen(highLimit, extended);
    lowS          = widen(lowLimit, extended);
    atOrAboveHigh = (sampleS >= highS);
    belowLow      = (sampleS < lowS);
    needed        = faultsNeeded(faultSel);
    cmpFault      = strobes.cmpWatchLow ? belowLow : atOrAboveHigh;
    intFault      = strobes.intWatchLow ? belowLow : atOrAboveHigh;
    cmpHit        = strobes.cmpCount && cmpFault && ((cmpCnt + CNT_W'(1)) >= needed);
    intHit        = strobes.intCount && intFault && ((intCnt + CNT_W'(1)) >= needed);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpCnt <= '0;
    end else if (strobes.cmpReset) begin
      cmpCnt <= '0;
    end else if (strobes.cmpCount) begin
      if (!cmpFault || cmpHit) cmpCnt <= '0;
      else                     cmpCnt <= cmpCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intCnt <= '0;
    end else if (strobes.intReset) begin
      intCnt <= '0;
    end else if (strobes.intCount) begin
      if (!intFault || intHit) intCnt <= '0;
      else                     intCnt <= intCnt + CNT_W'(1);
    end
  end

  // R1: a running count never reaches the largest queue depth
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rstN)
    (cmpCnt < CNT_W'(MAX_FAULTS)) && (intCnt < CNT_W'(MAX_FAULTS)));

  // R3: a non-fault result empties the comparator count
  p_nonfault_resets_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.cmpCount && !strobes.cmpReset && !cmpFault) |=> (cmpCnt == '0));

endmodule

// File: rtl/thermo_alert_ctrl.sv
module thermo_alert_ctrl
  import thermo_alert_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    resultValid,
  input  logic    intMode,
  input  logic    shutdown,
  input  logic    readClear,
  input  logic    respWon,
  input  logic    genCallReset,
  input  logic    cmpHit,
  input  logic    intHit,
  output strobe_t strobes,
  output logic    cmpAlert,
  output logic    intPending,
  output logic    causeLow
);

  logic watchLow;
  logic sdPrev;
  logic clearAny;

  always_comb begin
    clearAny            = readClear || respWon || (shutdown && !sdPrev);
    strobes.cmpCount    = resultValid && !genCallReset;
    strobes.cmpReset    = genCallReset;
    strobes.cmpWatchLow = cmpAlert;
    strobes.intCount    = resultValid && intMode && !intPending && !genCallReset;
    strobes.intReset    = genCallReset || !intMode;
    strobes.intWatchLow = watchLow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sdPrev <= 1'b0;
    else       sdPrev <= shutdown;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpAlert <= 1'b0;
    end else if (genCallReset) begin
      cmpAlert <= 1'b0;
    end else if (cmpHit) begin
      cmpAlert <= !cmpAlert;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intPending <= 1'b0;
      watchLow   <= 1'b0;
      causeLow   <= 1'b0;
    end else if (genCallReset || !intMode) begin
      intPending <= 1'b0;
      watchLow   <= 1'b0;
      causeLow   <= 1'b0;
    end else if (intPending && clearAny) begin
      intPending <= 1'b0;
      watchLow   <= !watchLow;
    end else if (intHit) begin
      intPending <= 1'b1;
      causeLow   <= watchLow;
    end
  end

  // R7: general-call reset empties both alert states
  p_gencall_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    genCallReset |=> (!cmpAlert && !intPending));

  // R12: a clear wins over a same-cycle result while latched
  p_clear_wins_r12: assert property (@(posedge clk) disable iff (!rstN)
    (intMode && intPending && clearAny && !genCallReset) |=> !intPending);

  // R3: the comparator state moves only on a result
  p_cmp_needs_result_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!resultValid && !genCallReset) |=> $stable(cmpAlert));

  // R4: an interrupt latches only on a result
  p_int_needs_result_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intPending) |-> $past(resultValid));

endmodule

// File: rtl/thermo_alert.sv
module thermo_alert
  import thermo_alert_pkg::*;
#(
  parameter int DATA_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              resultValid,
  input  logic [DATA_W-1:0] resultCode,
  input  logic [DATA_W-1:0] highLimit,
  input  logic [DATA_W-1:0] lowLimit,
  input  logic              cfgIntMode,
  input  logic              cfgPolHigh,
  input  logic [1:0]        cfgFaultSel,
  input  logic              cfgExtended,
  input  logic              cfgShutdown,
  input  logic              readClear,
  input  logic              respWon,
  input  logic              genCallReset,
  output logic              alertPin,
  output logic              alertStatus,
  output logic              respCause
);

  strobe_t strobes;
  logic    cmpHit;
  logic    intHit;
  logic    cmpAlert;
  logic    intPending;
  logic    causeLow;
  logic    active;

  thermo_alert_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .resultValid  (resultValid),
    .intMode      (cfgIntMode),
    .shutdown     (cfgShutdown),
    .readClear    (readClear),
    .respWon      (respWon),
    .genCallReset (genCallReset),
    .cmpHit       (cmpHit),
    .intHit       (intHit),
    .strobes      (strobes),
    .cmpAlert     (cmpAlert),
    .intPending   (intPending),
    .causeLow     (causeLow)
  );

  thermo_alert_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .sample    (resultCode),
    .highLimit (highLimit),
    .lowLimit  (lowLimit),
    .extended  (cfgExtended),
    .faultSel  (cfgFaultSel),
    .cmpHit    (cmpHit),
    .intHit    (intHit)
  );

  always_comb begin
    active      = cfgIntMode ? intPending : cmpAlert;
    alertPin    = cfgPolHigh ? active : !active;
    alertStatus = cfgPolHigh ? cmpAlert : !cmpAlert;
    respCause   = (cfgIntMode && causeLow) ^ cfgPolHigh;
  end

  // R9: in comparator behaviour the pin and the status bit agree
  p_pin_matches_status_r9: assert property (@(posedge clk) disable iff (!rstN)
    !cfgIntMode |-> (alertPin == alertStatus));

endmodule

// File: tb/thermo_alert_tb.sv
module thermo_alert_tb;
  timeunit 1ns; timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        resultValid = 1'b0;
  logic [12:0] resultCode = '0;
  logic [12:0] highLimit = 13'h0500;
  logic [12:0] lowLimit  = 13'h04B0;
  logic        cfgIntMode = 1'b0;
  logic        cfgPolHigh = 1'b0;
  logic [1:0]  cfgFaultSel = 2'b00;
  logic        cfgExtended = 1'b1;
  logic        cfgShutdown = 1'b0;
  logic        readClear = 1'b0;
  logic        respWon = 1'b0;
  logic        genCallReset = 1'b0;
  logic        alertPin, alertStatus, respCause;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  bit done    = 0;

  // bench model state
  bit mComp, mPend, mWl, mCause, mSdPrev;
  int mCc, mIc;

  always #10 clk = ~clk;

  thermo_alert u_dut (
    .clk(clk), .rstN(rstN), .resultValid(resultValid), .resultCode(resultCode),
    .highLimit(highLimit), .lowLimit(lowLimit), .cfgIntMode(cfgIntMode),
    .cfgPolHigh(cfgPolHigh), .cfgFaultSel(cfgFaultSel), .cfgExtended(cfgExtended),
    .cfgShutdown(cfgShutdown), .readClear(readClear), .respWon(respWon),
    .genCallReset(genCallReset), .alertPin(alertPin), .alertStatus(alertStatus),
    .respCause(respCause)
  );

  function automatic int needN(input logic [1:0] s);
    case (s)
      2'b00: return 1;
      2'b01: return 2;
      2'b10: return 4;
      default: return 6;
    endcase
  endfunction

  function automatic int toInt(input logic [12:0] v, input bit wide);
    int r;
    if (wide) r = v[12] ? int'(v) - 8192 : int'(v);
    else      r = v[11] ? int'(v[11:0]) - 4096 : int'(v[11:0]);
    return r;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0b expected=%0b at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic mStep(input bit v, input logic [12:0] code, input bit clr, input bit gc);
    int t, h, l, n;
    bit f;
    if (gc) begin
      mComp = 0; mPend = 0; mWl = 0; mCause = 0; mCc = 0; mIc = 0;
      return;
    end
    t = toInt(code, cfgExtended);
    h = toInt(highLimit, cfgExtended);
    l = toInt(lowLimit, cfgExtended);
    n = needN(cfgFaultSel);
    if (v) begin
      f = mComp ? (t < l) : (t >= h);
      if (!f) mCc = 0;
      else if (mCc + 1 >= n) begin mComp = !mComp; mCc = 0; end
      else mCc++;
    end
    if (!cfgIntMode) begin
      mPend = 0; mWl = 0; mCause = 0; mIc = 0;
    end else if (mPend && clr) begin
      mPend = 0; mWl = !mWl;
    end else if (v && !mPend) begin
      f = mWl ? (t < l) : (t >= h);
      if (!f) mIc = 0;
      else if (mIc + 1 >= n) begin mPend = 1; mCause = mWl; mIc = 0; end
      else mIc++;
    end
  endtask

  // one cycle of stimulus; inputs change at the falling edge, outputs read at the next one
  task automatic step(input bit v, input logic [12:0] code, input bit rc,
                      input bit rw, input bit gc, input bit sd);
    bit sdRise;
    @(negedge clk);
    resultValid = v; resultCode = code; readClear = rc; respWon = rw;
    genCallReset = gc; cfgShutdown = sd;
    sdRise = sd && !mSdPrev;
    mSdPrev = sd;
    mStep(v, code, rc || rw || sdRise, gc);
    @(posedge clk);
    @(negedge clk);
    resultValid = 0; readClear = 0; respWon = 0; genCallReset = 0;
  endtask

  task automatic res(input logic [12:0] code);
    step(1, code, 0, 0, 0, cfgShutdown);
  endtask

  task automatic gcall();
    step(0, '0, 0, 0, 1, cfgShutdown);
  endtask

  task automatic modelChecks(input string tagPin, input string tagSt, input string tagCause);
    bit act;
    act = cfgIntMode ? mPend : mComp;
    chk(tagPin, alertPin, cfgPolHigh ? act : !act);
    chk(tagSt, alertStatus, cfgPolHigh ? mComp : !mComp);
    chk(tagCause, respCause, (cfgIntMode && mCause) ^ cfgPolHigh);
  endtask

  function automatic logic [12:0] patVal(input int i);
    if (i < 10)      return (i == 4)  ? 13'h04C0 : 13'h0500 + 13'(i);
    else if (i < 20) return (i == 14) ? 13'h04B0 : 13'h0400 + 13'(i - 10);
    else if (i < 30) return 13'h07FF;
    else if (i < 40) return 13'h1E70;
    else             return 13'h0600;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    mComp = 0; mPend = 0; mWl = 0; mCause = 0; mCc = 0; mIc = 0; mSdPrev = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state: idle outputs for active-low polarity
    chk("R8 reset pin", alertPin, 1'b1);
    chk("R9 reset status", alertStatus, 1'b1);
    chk("R10 reset cause", respCause, 1'b0);

    // R1: exact queue depth for every select value
    for (int s = 0; s < 4; s++) begin
      cfgFaultSel = 2'(s);
      gcall();
      for (int k = 0; k < needN(2'(s)) - 1; k++) res(13'h0500);
      chk("R1 one short of depth", alertPin, 1'b1);
      res(13'h0500);
      chk("R1 depth reached", alertPin, 1'b0);
    end

    // R2/R3: interrupted runs and the lower boundary
    cfgFaultSel = 2'b01;
    gcall();
    res(13'h0500); res(13'h04C0); res(13'h0500);
    chk("R3 nonfault resets count", alertPin, 1'b1);
    res(13'h0500);
    chk("R2 alert after two at high", alertPin, 1'b0);
    res(13'h04B0); res(13'h04B0);
    chk("R3 equal to low is no release", alertPin, 1'b0);
    res(13'h04AF);
    chk("R3 one below low not enough", alertPin, 1'b0);
    res(13'h04AF);
    chk("R3 released", alertPin, 1'b1);
    chk("R9 status released", alertStatus, 1'b1);

    // R11: narrow and wide interpretation
    cfgFaultSel = 2'b00;
    cfgExtended = 1'b0;
    gcall();
    res(13'h0800);
    chk("R11 narrow 0x800 negative", alertPin, 1'b1);
    res(13'h1500);
    chk("R11 narrow ignores bit 12", alertPin, 1'b0);
    cfgExtended = 1'b1;
    gcall();
    res(13'h0800);
    chk("R11 wide 0x800 positive", alertPin, 1'b0);

    // R7: general-call reset
    gcall();
    chk("R7 pin cleared", alertPin, 1'b1);
    chk("R7 status cleared", alertStatus, 1'b1);

    // R4/R5/R6/R10/R12: interrupt behaviour
    cfgIntMode = 1'b1;
    gcall();
    res(13'h0500);
    chk("R4 latched", alertPin, 1'b0);
    chk("R10 cause high", respCause, 1'b0);
    res(13'h0500);
    chk("R4 stays latched", alertPin, 1'b0);
    step(0, '0, 1, 0, 0, 0);
    chk("R4 read clears", alertPin, 1'b1);
    chk("R9 status unaffected by mode", alertStatus, 1'b0);
    res(13'h0600);
    chk("R5 high ignored while watching low", alertPin, 1'b1);
    res(13'h0400);
    chk("R5 latched on low", alertPin, 1'b0);
    chk("R10 cause low", respCause, 1'b1);
    step(0, '0, 0, 1, 0, 0);
    chk("R4 response clears", alertPin, 1'b1);
    res(13'h0400);
    chk("R5 back to watching high", alertPin, 1'b1);
    res(13'h0500);
    chk("R5 latched on high again", alertPin, 1'b0);
    step(0, '0, 0, 0, 0, 1);
    chk("R6 shutdown entry clears", alertPin, 1'b1);
    step(0, '0, 0, 0, 0, 0);
    step(1, 13'h0400, 1, 0, 0, 0);
    chk("R5 clear with nothing latched ignored", alertPin, 1'b0);
    step(1, 13'h0400, 1, 0, 0, 0);
    chk("R12 clear wins over result", alertPin, 1'b1);
    res(13'h0400);
    chk("R12 result after clear not latched", alertPin, 1'b1);
    @(negedge clk);
    cfgPolHigh = 1'b1;
    #1;
    chk("R8 active high idle", alertPin, 1'b0);
    res(13'h0500);
    chk("R8 active high alert", alertPin, 1'b1);
    chk("R10 cause inverted", respCause, 1'b1);
    chk("R9 status inverted", alertStatus, 1'b1);

    // sweep: every depth, both behaviours, polarities and widths
    for (int cfg = 0; cfg < 32; cfg++) begin
      @(negedge clk);
      cfgFaultSel = 2'(cfg & 3);
      cfgIntMode  = cfg[2];
      cfgPolHigh  = cfg[3];
      cfgExtended = cfg[4];
      gcall();
      for (int i = 0; i < 48; i++) begin
        if (i == 21) step(0, '0, 1, 0, 0, 0);
        if (i == 35) step(0, '0, 0, 1, 0, 0);
        res(patVal(i));
        modelChecks("R2 R4 R8 sweep pin", "R3 R9 sweep status", "R5 R10 sweep cause");
      end
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule